// File: doc/BRIEF.md
# Block Cipher CPU Data Port

This block is the processor-facing data path of a block cipher when no DMA engine moves the data. Software pushes 32-bit words into a small input buffer through a write strobe and pulls 32-bit results from an output buffer through a read strobe. When the input buffer holds a whole block and the port is running, the 128-bit block goes to the cipher core over a valid/ready handshake. The core returns its 128-bit result over a second valid/ready handshake, and the port accepts it only when the output buffer is empty.

Neither CPU port stalls. A write into a full input buffer is dropped. A read from an empty output buffer returns no result. Each of these sets a sticky detail flag, and each feeds a shared error interrupt flag. A separate done flag marks the end of a run, which is the point where the result of the block marked as final has been read out completely. Both flags are cleared by a write-1 strobe and are masked into one interrupt line by their own enables. Each data path can optionally reverse the byte order of its words.

Top module: `cdp_port`

## Requirements
- R1: After reset, busy, the done flag, the error flag, both detail error flags and irq are 0. Both empty flags are 1 and both full flags are 0.
- R2: The input buffer holds 4 words. in_empty is 1 only with 0 words stored, and in_full is 1 only with 4 words stored. Write words 0..3 of a block land in bits [31:0]..[127:96] of the block handed to the core.
- R3: A write while in_full is 1 is dropped and does not change the stored block. From the next cycle it sets in_err, and in_err stays set.
- R4: A read while out_empty is 1 sets out_err from the next cycle, and out_err stays set. The output buffer holds 4 words, and successive reads return result bits [31:0], [63:32], [95:64], [127:96].
- R5: A start strobe sets busy in the next cycle and clears in_err and out_err. A start strobe wins over a stop strobe in the same cycle.
- R6: Blocks move to or from the core only while busy is 1. A returned block is taken only when the output buffer is empty, after which out_full is 1 and out_empty is 0.
- R7: With in_swap at 1, a written word {b3,b2,b1,b0} is stored as {b0,b1,b2,b3}. With out_swap at 1, a read word is returned byte-reversed in the same way.
- R8: After a last-block strobe, the next block handed to the core is the final block. Reading the last word of its result clears busy and sets done_flag in the next cycle.
- R9: done_flag and err_flag are cleared by their clear strobes. A set event in the same cycle as a clear wins. Every in_err or out_err event sets err_flag.
- R10: irq is 1 exactly when (done_flag and done_ie) or (err_flag and err_ie) is true.
- R11: A stop strobe clears busy in the next cycle. No block is then handed to the core, and the buffered words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU write strobe into the input buffer |
| wr_data | input | 32 | CPU write data |
| rd_en | input | 1 | CPU read strobe, pops one output word |
| rd_data | output | 32 | Output word at the head of the buffer |
| start | input | 1 | Start strobe |
| stop | input | 1 | Stop strobe |
| last_mark | input | 1 | Marks the next handed-off block as final |
| in_swap | input | 1 | Byte-reverse written words |
| out_swap | input | 1 | Byte-reverse read words |
| done_ie | input | 1 | Done interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| clr_done | input | 1 | Write-1 clear of done_flag |
| clr_err | input | 1 | Write-1 clear of err_flag |
| busy | output | 1 | Run in progress |
| in_empty | output | 1 | Input buffer holds no words |
| in_full | output | 1 | Input buffer holds a whole block |
| in_err | output | 1 | Sticky: write into full buffer |
| out_empty | output | 1 | Output buffer holds no words |
| out_full | output | 1 | Output buffer holds a whole block |
| out_err | output | 1 | Sticky: read from empty buffer |
| done_flag | output | 1 | Run finished flag |
| err_flag | output | 1 | Buffer error interrupt flag |
| irq | output | 1 | Masked interrupt request |
| core_in_valid | output | 1 | Block offered to the core |
| core_in_ready | input | 1 | Core accepts the block |
| core_in_data | output | 128 | Block to the core |
| core_out_valid | input | 1 | Core offers a result |
| core_out_ready | output | 1 | Port accepts the result |
| core_out_data | input | 128 | Result from the core |

## Verification
On every cycle, the assertions check that the word counts stay in range, that a full-buffer write or an empty-buffer read raises its sticky flag one cycle later, that a start yields busy, that a new done flag only appears once busy is low, and that a clear takes effect when no set event competes with it. Only the bench scenarios can show the data itself: that blocks are packed and unpacked in word order, that the byte reversal is right, that a dropped write leaves the block intact, and that the whole last-block run ends with done and an interrupt that follows its masks.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
  localparam int WORD_W = 32;
  localparam int BLK_WORDS = 4;

  // Reverse the byte order of a data word: {b3,b2,b1,b0} -> {b0,b1,b2,b3}
  function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W/8; i++) begin
      r[i*8 +: 8] = w[(WORD_W/8-1-i)*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] opt_rev(input logic [WORD_W-1:0] w, input logic en);
    return en ? byte_rev(w) : w;
  endfunction
endpackage

// File: rtl/cdp_inbuf.sv
module cdp_inbuf
  import cdp_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = BLK_WORDS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_data,
  input  logic           swap,
  input  logic           enable,
  input  logic           err_clr,
  output logic           blk_valid,
  input  logic           blk_ready,
  output logic [N*W-1:0] blk_data,
  output logic           empty,
  output logic           full,
  output logic           err,
  output logic           err_evt,
  output logic           xfer
);
  localparam int CW = $clog2(N+1);
  localparam logic [CW-1:0] CNT_FULL = CW'(N);

  logic [W-1:0]  mem [N];
  logic [CW-1:0] cnt;
  logic          wr_ok;

  assign full      = (cnt == CNT_FULL);
  assign empty     = (cnt == '0);
  assign blk_valid = full && enable;
  assign xfer      = blk_valid && blk_ready;
  assign wr_ok     = wr_en && !full;
  assign err_evt   = wr_en && full;

  for (genvar g = 0; g < N; g++) begin : g_pack
    assign blk_data[g*W +: W] = mem[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      err <= 1'b0;
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else begin
      if (xfer) cnt <= '0;
      else if (wr_ok) begin
        mem[cnt[$clog2(N)-1:0]] <= opt_rev(wr_data, swap);
        cnt <= cnt + 1'b1;
      end
      if (err_clr) err <= 1'b0;
      else if (err_evt) err <= 1'b1;
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_FULL);
  p_reject_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !err_clr) |=> err);
endmodule

// File: rtl/cdp_outbuf.sv
module cdp_outbuf
  import cdp_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = BLK_WORDS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_en,
  output logic [W-1:0]   rd_data,
  input  logic           swap,
  input  logic           enable,
  input  logic           err_clr,
  input  logic           blk_valid,
  output logic           blk_ready,
  input  logic [N*W-1:0] blk_data,
  output logic           empty,
  output logic           full,
  output logic           err,
  output logic           err_evt,
  output logic           load,
  output logic           drain_last
);
  localparam int CW = $clog2(N+1);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] CNT_FULL = CW'(N);

  logic [W-1:0]  mem [N];
  logic [CW-1:0] cnt;
  logic [PW-1:0] ptr;
  logic          pop;

  assign empty      = (cnt == '0);
  assign full       = (cnt == CNT_FULL);
  assign blk_ready  = empty && enable;
  assign load       = blk_valid && blk_ready;
  assign pop        = rd_en && !empty;
  assign err_evt    = rd_en && empty;
  assign drain_last = pop && (cnt == CW'(1));
  assign rd_data    = opt_rev(mem[ptr], swap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ptr <= '0;
      err <= 1'b0;
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else begin
      if (load) begin
        for (int i = 0; i < N; i++) mem[i] <= blk_data[i*W +: W];
        cnt <= CNT_FULL;
        ptr <= '0;
      end else if (pop) begin
        cnt <= cnt - 1'b1;
        ptr <= ptr + 1'b1;
      end
      if (err_clr) err <= 1'b0;
      else if (err_evt) err <= 1'b1;
    end
  end

  p_out_range_r4: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_FULL);
  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !err_clr) |=> err);
  p_load_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> full);
endmodule

// File: rtl/cdp_ctrl.sv
module cdp_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic last_mark,
  input  logic in_xfer,
  input  logic out_load,
  input  logic drain_last,
  input  logic err_evt,
  input  logic done_ie,
  input  logic err_ie,
  input  logic clr_done,
  input  logic clr_err,
  output logic busy,
  output logic done_flag,
  output logic err_flag,
  output logic irq
);
  logic last_pend, final_sent, final_out;
  logic done_evt;

  assign done_evt = busy && final_out && drain_last;
  assign irq = (done_flag && done_ie) || (err_flag && err_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      last_pend  <= 1'b0;
      final_sent <= 1'b0;
      final_out  <= 1'b0;
      done_flag  <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      if (start) busy <= 1'b1;
      else if (stop || done_evt) busy <= 1'b0;

      if (start || done_evt) begin
        last_pend  <= last_mark;
        final_sent <= 1'b0;
        final_out  <= 1'b0;
      end else begin
        if (last_mark) last_pend <= 1'b1;
        if (in_xfer && (last_pend || last_mark)) begin
          final_sent <= 1'b1;
          last_pend  <= 1'b0;
        end
        if (out_load && final_sent) final_out <= 1'b1;
      end

      if (done_evt) done_flag <= 1'b1;
      else if (clr_done) done_flag <= 1'b0;
      if (err_evt) err_flag <= 1'b1;
      else if (clr_err) err_flag <= 1'b0;
    end
  end

  p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> !busy);
  p_clr_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !done_evt) |=> !done_flag);
  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n) err_evt |=> err_flag);
  p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !busy);
endmodule

// File: rtl/cdp_port.sv
module cdp_port
  import cdp_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = BLK_WORDS,
  localparam int BW = W * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  input  logic          start,
  input  logic          stop,
  input  logic          last_mark,
  input  logic          in_swap,
  input  logic          out_swap,
  input  logic          done_ie,
  input  logic          err_ie,
  input  logic          clr_done,
  input  logic          clr_err,
  output logic          busy,
  output logic          in_empty,
  output logic          in_full,
  output logic          in_err,
  output logic          out_empty,
  output logic          out_full,
  output logic          out_err,
  output logic          done_flag,
  output logic          err_flag,
  output logic          irq,
  output logic          core_in_valid,
  input  logic          core_in_ready,
  output logic [BW-1:0] core_in_data,
  input  logic          core_out_valid,
  output logic          core_out_ready,
  input  logic [BW-1:0] core_out_data
);
  logic in_err_evt, out_err_evt, in_xfer, out_load, drain_last;

  cdp_inbuf #(.W(W), .N(N)) u_inbuf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .swap(in_swap),
    .enable(busy), .err_clr(start), .blk_valid(core_in_valid), .blk_ready(core_in_ready),
    .blk_data(core_in_data), .empty(in_empty), .full(in_full), .err(in_err),
    .err_evt(in_err_evt), .xfer(in_xfer));

  cdp_outbuf #(.W(W), .N(N)) u_outbuf (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data), .swap(out_swap),
    .enable(busy), .err_clr(start), .blk_valid(core_out_valid), .blk_ready(core_out_ready),
    .blk_data(core_out_data), .empty(out_empty), .full(out_full), .err(out_err),
    .err_evt(out_err_evt), .load(out_load), .drain_last(drain_last));

  cdp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .last_mark(last_mark),
    .in_xfer(in_xfer), .out_load(out_load), .drain_last(drain_last),
    .err_evt(in_err_evt || out_err_evt), .done_ie(done_ie), .err_ie(err_ie),
    .clr_done(clr_done), .clr_err(clr_err), .busy(busy), .done_flag(done_flag),
    .err_flag(err_flag), .irq(irq));

  p_handoff_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_in_valid || core_out_ready) |-> busy);
  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_ie && !err_ie) |-> !irq);
endmodule

// File: tb/cdp_port_bench.sv
module cdp_port_bench;
  localparam logic [127:0] MASK = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, start = 0, stop = 0, last_mark = 0;
  logic in_swap = 0, out_swap = 0, done_ie = 0, err_ie = 0, clr_done = 0, clr_err = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic busy, in_empty, in_full, in_err, out_empty, out_full, out_err;
  logic done_flag, err_flag, irq;
  logic core_in_valid, core_in_ready, core_out_valid, core_out_ready;
  logic [127:0] core_in_data, core_out_data;

  int checks = 0, fails = 0;
  logic [31:0] expq[$];
  logic [31:0] pend[4];

  always #4 clk = ~clk;

  cdp_port u_cdp_port (.*);

  // cipher stand-in: result = block ^ MASK after a short delay
  logic m_full = 0;
  logic [127:0] m_data = '0;
  int m_dly = 0;
  assign core_in_ready  = !m_full;
  assign core_out_valid = m_full && (m_dly == 0);
  assign core_out_data  = m_data ^ MASK;
  always @(posedge clk) begin
    if (core_in_valid && !m_full) begin
      m_full <= 1'b1; m_data <= core_in_data; m_dly <= 3;
    end else if (m_full) begin
      if (m_dly != 0) m_dly <= m_dly - 1;
      else if (core_out_ready) m_full <= 1'b0;
    end
  end

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // driver: write one block and push the expected result words
  task automatic drive_block(input logic [31:0] w0, input logic [31:0] w1,
                             input logic [31:0] w2, input logic [31:0] w3);
    logic [127:0] blk;
    pend[0] = w0; pend[1] = w1; pend[2] = w2; pend[3] = w3;
    for (int i = 0; i < 4; i++) begin
      blk[i*32 +: 32] = in_swap ? rev(pend[i]) : pend[i];
      wr(pend[i]);
    end
    blk = blk ^ MASK;
    for (int i = 0; i < 4; i++)
      expq.push_back(out_swap ? rev(blk[i*32 +: 32]) : blk[i*32 +: 32]);
  endtask

  // monitor: wait for a result block, pop and compare each word
  task automatic drain_block(input string tag);
    int n = 0;
    while (!out_full && n < 100) begin @(negedge clk); n++; end
    chk(out_full && !out_empty, "R6 result block buffered", {out_full, out_empty}, 2'b10);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] e;
      @(negedge clk);
      e = expq.pop_front();
      chk(rd_data === e, tag, rd_data, e);
      rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
    end
  endtask

  initial begin
    int wd = 0;
    while (wd < 20000) begin @(posedge clk); wd++; end
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", wd);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({busy, done_flag, err_flag, in_err, out_err, irq} == 0, "R1 flags low", {busy, done_flag, err_flag, in_err, out_err, irq}, 0);
    chk({in_empty, in_full, out_empty, out_full} == 4'b1010, "R1 buffer flags", {in_empty, in_full, out_empty, out_full}, 4'b1010);

    // R2 fill while idle, R6 nothing handed off while idle
    drive_block(32'h11223344, 32'h55667788, 32'h99AABBCC, 32'hDDEEFF00);
    chk(in_full && !in_empty, "R2 full after four words", {in_full, in_empty}, 2'b10);
    repeat (5) @(negedge clk);
    chk(!core_in_valid && in_full, "R6 no handoff while idle", {core_in_valid, in_full}, 2'b01);

    // R3 write into full buffer is dropped, sets in_err and err_flag
    wr(32'hDEADBEEF);
    chk(in_err === 1'b1, "R3 in_err set", in_err, 1);
    chk(err_flag === 1'b1, "R9 err_flag set by in_err", err_flag, 1);
    chk(irq === 1'b0, "R10 irq masked", irq, 0);
    err_ie = 1'b1; #1;
    chk(irq === 1'b1, "R10 irq with err_ie", irq, 1);
    pulse(clr_err);
    chk(err_flag === 1'b0 && irq === 1'b0, "R9 clr_err", {err_flag, irq}, 0);

    // R4 read while empty
    pulse(rd_en);
    chk(out_err === 1'b1 && err_flag === 1'b1, "R4 out_err on empty read", {out_err, err_flag}, 2'b11);
    pulse(clr_err);
    err_ie = 1'b0;

    // R5 start sets busy, clears detail flags
    pulse(start);
    chk(busy === 1'b1, "R5 busy after start", busy, 1);
    chk(!in_err && !out_err, "R5 detail errors cleared", {in_err, out_err}, 0);
    // R3/R4 dropped word absent, word order correct
    drain_block("R4 result word order (R3 dropped write absent)");
    chk(out_empty === 1'b1 && busy === 1'b1, "R8 busy held without last marker", {out_empty, busy}, 2'b11);

    // R7 swaps + R8 final block
    in_swap = 1'b1; out_swap = 1'b1; done_ie = 1'b1;
    pulse(last_mark);
    drive_block(32'h01020304, 32'hA0B0C0D0, 32'hCAFEF00D, 32'h13579BDF);
    drain_block("R7 swapped result word");
    @(negedge clk);
    chk(busy === 1'b0 && done_flag === 1'b1, "R8 done after final read", {busy, done_flag}, 2'b01);
    chk(irq === 1'b1, "R10 irq on done", irq, 1);
    pulse(clr_done);
    chk(done_flag === 1'b0 && irq === 1'b0, "R9 clr_done", {done_flag, irq}, 0);
    in_swap = 1'b0; out_swap = 1'b0;

    // R11 stop halts handoff, keeps words
    pulse(start);
    pulse(stop);
    chk(busy === 1'b0, "R11 stop clears busy", busy, 0);
    drive_block(32'h0BADCAFE, 32'h00000001, 32'h80000000, 32'h7FFFFFFF);
    repeat (6) @(negedge clk);
    chk(in_full && !core_in_valid && out_empty, "R11 halted, block kept", {in_full, core_in_valid, out_empty}, 3'b101);
    pulse(start);
    drain_block("R11 kept block processed after restart");
    chk(expq.size() == 0, "R2 scoreboard drained", expq.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule